// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Unit

This unit sits beside a small multi-cycle CPU and turns two external requests into control transfers. One request comes from a number-entry source and the other from a start button. Both are latched as pending. At an instruction boundary the unit checks whether interrupts are allowed. If they are, it hands the CPU the handler address of the winning source and asks for a PC load in the same cycle. It keeps the next-instruction PC in a hidden return register and sets a masking bit so that servicing cannot nest.

Software reaches the unit through decoded special-register writes. Two of the register numbers hold handler addresses, one holds a display value, and one holds the mask bit. A mask-toggle instruction flips the bit, which lets a program shut requests out around a computation and open them again afterwards. The return instruction runs in two cycles. In the first it registers the request. In the second it puts the saved PC on the bus and clears both the mask and the in-service flag, so the flag stays set until the last cycle of servicing.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset the mask bit is 1 (blocked), the in-service flag is 0, the display value is 0, and neither take nor PC-load is asserted.
- R2: A special-register write to number 0x0 sets the number-source handler address, 0x1 sets the start-source handler address, 0x2 sets the display value, and 0xF loads bit 0 of the write data into the mask bit. A write to any other number changes nothing. Each write is visible on the cycle after it.
- R3: When the boundary input is high, the mask bit is 0 and a request is pending, take and PC-load rise in that same cycle and the PC output carries the handler address of the winning source.
- R4: When both sources are pending, the number source wins. The start source stays pending and is taken at a later boundary.
- R5: On the cycle after a take, the mask bit and the in-service flag both read 1.
- R6: A request that arrives while the mask bit is 1 is held pending and is not taken. It is taken at the first boundary after the mask returns to 0.
- R7: A mask-toggle pulse inverts the mask bit. The new value is visible on the next cycle.
- R8: A return request yields a PC load exactly one cycle later, carrying the PC that was saved at the take. One cycle after that load, the mask bit and the in-service flag read 0.
- R9: No take occurs while the boundary input is low, even with a request pending and the mask bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_num_i | input | 1 | Number-entry interrupt request |
| req_start_i | input | 1 | Start interrupt request |
| bound_i | input | 1 | CPU is at an instruction boundary |
| pc_i | input | PC_W | Next-instruction PC, saved on a take |
| maski_i | input | 1 | Mask-toggle instruction pulse |
| rfi_i | input | 1 | Return-from-interrupt instruction pulse |
| sr_we_i | input | 1 | Special-register write enable |
| sr_addr_i | input | 4 | Special-register number |
| sr_wdata_i | input | PC_W | Special-register write data |
| take_o | output | 1 | Interrupt accepted this cycle |
| pc_load_o | output | 1 | CPU must load pc_o this cycle |
| pc_o | output | PC_W | Handler address or return PC |
| mask_o | output | 1 | Mask bit, 1 means blocked |
| busy_o | output | 1 | Interrupt in service |
| disp_o | output | PC_W | Display register value |

## Verification
Take, PC-load and the handler address are combinational, so they are due in the same cycle as the boundary that accepts them. The bench samples them shortly after it drives the inputs. Mask, in-service and special-register effects land on the following edge. The return PC appears one edge after the return request, and the cleared mask one edge after that. The bench drives on the falling edge and samples each of these results on the exact falling edge that the count of registers predicts. A sweep over every combination of pending sources, with the mask both open and closed, checks the vector choice, the order of takes and the held requests against values the bench computes itself.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned SR_AW = 4;
  localparam logic [SR_AW-1:0] SR_VEC_NUM   = 4'h0;
  localparam logic [SR_AW-1:0] SR_VEC_START = 4'h1;
  localparam logic [SR_AW-1:0] SR_DISP      = 4'h2;
  localparam logic [SR_AW-1:0] SR_MASK      = 4'hF;
  localparam int unsigned N_SRC = 2;
  typedef enum logic [0:0] {SRC_NUM = 1'b0, SRC_START = 1'b1} src_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= (pend_q & ~clr_i[g]) | req_i[g];
    end
    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/irq_sreg.sv
module irq_sreg
  import irq_vec_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SR_AW-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    vec_num_o,
  output logic [DW-1:0]    vec_start_o,
  output logic [DW-1:0]    disp_o,
  output logic             mask_we_o,
  output logic             mask_bit_o
);
  logic [DW-1:0] vec_num_q, vec_start_q, disp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_num_q   <= '0;
      vec_start_q <= '0;
      disp_q      <= '0;
    end else if (we_i) begin
      case (addr_i)
        SR_VEC_NUM:   vec_num_q   <= wdata_i;
        SR_VEC_START: vec_start_q <= wdata_i;
        SR_DISP:      disp_q      <= wdata_i;
        default: ;
      endcase
    end
  end

  assign vec_num_o   = vec_num_q;
  assign vec_start_o = vec_start_q;
  assign disp_o      = disp_q;
  assign mask_we_o   = we_i && (addr_i == SR_MASK);
  assign mask_bit_o  = wdata_i[0];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bound_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic             maski_i,
  input  logic             rfi_i,
  input  logic             mask_we_i,
  input  logic             mask_bit_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  vec_num_i,
  input  logic [PC_W-1:0]  vec_start_i,
  output logic [N_SRC-1:0] clr_o,
  output logic             take_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             mask_o,
  output logic             busy_o,
  output logic             rfi_stage_o
);
  logic            mask_q, busy_q, rfi_q;
  logic [PC_W-1:0] ret_q;
  src_e            win;

  // number source has fixed priority
  assign win    = pend_i[SRC_NUM] ? SRC_NUM : SRC_START;
  assign take_o = bound_i && !mask_q && !rfi_q && (|pend_i);

  always_comb begin
    clr_o = '0;
    if (take_o) clr_o[win] = 1'b1;
  end

  assign pc_load_o = take_o || rfi_q;
  assign pc_o      = rfi_q ? ret_q : ((win == SRC_NUM) ? vec_num_i : vec_start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
      busy_q <= 1'b0;
      rfi_q  <= 1'b0;
      ret_q  <= '0;
    end else begin
      rfi_q <= rfi_i && !rfi_q && !take_o;
      if (take_o) ret_q <= pc_i;
      // the finishing return cycle has the highest priority on mask and busy
      if (rfi_q) begin
        mask_q <= 1'b0;
        busy_q <= 1'b0;
      end else if (take_o) begin
        mask_q <= 1'b1;
        busy_q <= 1'b1;
      end else if (maski_i) begin
        mask_q <= !mask_q;
      end else if (mask_we_i) begin
        mask_q <= mask_bit_i;
      end
    end
  end

  assign mask_o      = mask_q;
  assign busy_o      = busy_q;
  assign rfi_stage_o = rfi_q;
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_vec_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_num_i,
  input  logic             req_start_i,
  input  logic             bound_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             maski_i,
  input  logic             rfi_i,
  input  logic             sr_we_i,
  input  logic [SR_AW-1:0] sr_addr_i,
  input  logic [PC_W-1:0]  sr_wdata_i,
  output logic             take_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             mask_o,
  output logic             busy_o,
  output logic [PC_W-1:0]  disp_o
);
  logic [N_SRC-1:0] req, pend, clr;
  logic [PC_W-1:0]  vec_num, vec_start;
  logic             mask_we, mask_bit, rfi_stage;

  assign req[SRC_NUM]   = req_num_i;
  assign req[SRC_START] = req_start_i;

  irq_pend #(.N(N_SRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .clr_i (clr),
    .pend_o(pend)
  );

  irq_sreg #(.DW(PC_W)) u_sreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sr_we_i),
    .addr_i     (sr_addr_i),
    .wdata_i    (sr_wdata_i),
    .vec_num_o  (vec_num),
    .vec_start_o(vec_start),
    .disp_o     (disp_o),
    .mask_we_o  (mask_we),
    .mask_bit_o (mask_bit)
  );

  irq_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bound_i    (bound_i),
    .pend_i     (pend),
    .maski_i    (maski_i),
    .rfi_i      (rfi_i),
    .mask_we_i  (mask_we),
    .mask_bit_i (mask_bit),
    .pc_i       (pc_i),
    .vec_num_i  (vec_num),
    .vec_start_i(vec_start),
    .clr_o      (clr),
    .take_o     (take_o),
    .pc_load_o  (pc_load_o),
    .pc_o       (pc_o),
    .mask_o     (mask_o),
    .busy_o     (busy_o),
    .rfi_stage_o(rfi_stage)
  );
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bound_i,
  input logic maski_i,
  input logic rfi_i,
  input logic take_o,
  input logic pc_load_o,
  input logic mask_o,
  input logic busy_o,
  input logic rfi_stage
);
  a_r3_take_only_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (bound_i && !mask_o && pc_load_o));
  a_r5_take_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (mask_o && busy_o));
  a_r7_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (maski_i && !take_o && !rfi_stage) |=> (mask_o != $past(mask_o)));
  a_r8_return_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !rfi_stage && !take_o) |=> pc_load_o ##1 (!mask_o && !busy_o));
  a_r9_no_take_off_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |-> !take_o);
endmodule

bind irq_vec_unit irq_vec_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bound_i  (bound_i),
  .maski_i  (maski_i),
  .rfi_i    (rfi_i),
  .take_o   (take_o),
  .pc_load_o(pc_load_o),
  .mask_o   (mask_o),
  .busy_o   (busy_o),
  .rfi_stage(rfi_stage)
);

// File: tb/irq_vec_unit_tb.sv
module irq_vec_unit_tb_top;
  localparam int unsigned PC_W  = 16;
  localparam time         CLK_P = 10ns;
  localparam logic [PC_W-1:0] VN = 16'h0100;
  localparam logic [PC_W-1:0] VS = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_num = 0, req_start = 0, bound = 0, maski = 0, rfi = 0, sr_we = 0;
  logic [3:0] sr_addr = '0;
  logic [PC_W-1:0] pc = '0, sr_wdata = '0;
  logic take, pc_load, mask, busy;
  logic [PC_W-1:0] pc_out, disp;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_vec_unit #(.PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_num_i(req_num), .req_start_i(req_start),
    .bound_i(bound), .pc_i(pc), .maski_i(maski), .rfi_i(rfi),
    .sr_we_i(sr_we), .sr_addr_i(sr_addr), .sr_wdata_i(sr_wdata),
    .take_o(take), .pc_load_o(pc_load), .pc_o(pc_out), .mask_o(mask),
    .busy_o(busy), .disp_o(disp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sr_write(input logic [3:0] a, input logic [PC_W-1:0] d);
    sr_we = 1; sr_addr = a; sr_wdata = d;
    @(negedge clk);
    sr_we = 0;
  endtask

  task automatic pulse_req(input logic n, input logic s);
    req_num = n; req_start = s;
    @(negedge clk);
    req_num = 0; req_start = 0;
  endtask

  task automatic do_take(input logic [PC_W-1:0] p, input logic [PC_W-1:0] v, input string tag);
    bound = 1; pc = p; #1;
    chk({tag, " take"}, take, 1);
    chk({tag, " load"}, pc_load, 1);
    chk({tag, " vector"}, pc_out, v);
    @(negedge clk);
    bound = 0; #1;
    chk("R5 mask set", mask, 1);
    chk("R5 busy set", busy, 1);
  endtask

  task automatic do_rfi(input logic [PC_W-1:0] p);
    rfi = 1; #1;
    chk("R8 no load at request", pc_load, 0);
    @(negedge clk);
    rfi = 0; #1;
    chk("R8 load", pc_load, 1);
    chk("R8 return pc", pc_out, p);
    @(negedge clk); #1;
    chk("R8 mask clear", mask, 0);
    chk("R8 busy clear", busy, 0);
    chk("R8 load gone", pc_load, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 mask", mask, 1);
    chk("R1 busy", busy, 0);
    chk("R1 disp", disp, 0);
    chk("R1 take", take, 0);
    chk("R1 load", pc_load, 0);

    // R2 special-register writes
    sr_write(4'h2, 16'hBEEF); #1;
    chk("R2 display", disp, 16'hBEEF);
    sr_write(4'h3, 16'h1234); #1;
    chk("R2 ignored number", disp, 16'hBEEF);
    sr_write(4'h0, VN);
    sr_write(4'h1, VS);
    sr_write(4'h4, 16'h0999);
    sr_write(4'hF, 16'h0000); #1;
    chk("R2 mask write", mask, 0);

    // R9 no take off boundary
    pulse_req(1, 0); #1;
    chk("R9 no take", take, 0);
    @(negedge clk); #1;
    chk("R9 still no take", take, 0);
    do_take(16'h0040, VN, "R3");
    do_rfi(16'h0040);

    // R4 / R3 sweep over pending combinations
    for (int c = 1; c < 4; c++) begin
      logic [PC_W-1:0] p;
      p = 16'h1000 + PC_W'(c * 4);
      pulse_req(c[0], c[1]);
      if (c[0]) do_take(p, VN, "R4 first");
      else      do_take(p, VS, "R3 start");
      do_rfi(p);
      if (c == 3) begin
        do_take(p + 2, VS, "R4 second");
        do_rfi(p + 2);
      end
      #1 chk("R4 nothing left", take, 0);
      @(negedge clk);
    end

    // R6 / R7 masked requests held, toggle reopens
    for (int s = 0; s < 2; s++) begin
      maski = 1;
      @(negedge clk);
      maski = 0; #1;
      chk("R7 toggle to blocked", mask, 1);
      pulse_req(s == 0, s == 1);
      bound = 1; #1;
      chk("R6 masked no take", take, 0);
      @(negedge clk);
      bound = 0;
      maski = 1;
      @(negedge clk);
      maski = 0; #1;
      chk("R7 toggle to open", mask, 0);
      do_take(16'h2000 + PC_W'(s), (s == 0) ? VN : VS, "R6 held taken");
      do_rfi(16'h2000 + PC_W'(s));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule